// File: doc/BRIEF.md
# Instruction class decoder

This block turns an 8-bit instruction byte into a one-hot class vector for the control logic. It also presents, already split out, the parameter bits that belong to that class. The byte is taken from the instruction bus on a clock edge while a load strobe is high. All outputs then follow from that held copy until the next load.

The opcode map is prefix based. The classes that need the most parameter bits each take a whole quarter of the byte space through a two-bit prefix:
- register move under `00`
- A/B immediate set under `01`
- branch/call under `11`

The `10` quarter is shared by leaner classes. Here only the ALU class (`1000xxxx`) is assigned. Every other code in that quarter decodes to an explicit no-operation class.

The same one-hot vector is driven onto a second output that feeds front-panel indicators. Each field output reads zero unless its own class is the active one.

Top module: `instr_class_decoder`

## Requirements
- R1: While reset is held, and after reset until the first load, `class_oh`, `class_led` and all field outputs are zero.
- R2: The instruction byte is captured on a rising clock edge where `load` is 1. Outputs reflect the captured byte from the following cycle on. Edges with `load` at 0 leave every output unchanged, whatever `instr_in` does.
- R3: A captured byte `00pppppp` asserts `class_oh` bit 0 (move class), and `mov_arg` equals bits 5:0.
- R4: A captured byte `01rvvvvv` asserts `class_oh` bit 1 (A/B set class). `setab_sel` equals bit 5 (0 selects A, 1 selects B), and `setab_val` equals bits 4:0.
- R5: A captured byte `11ffffff` asserts `class_oh` bit 3 (branch class), and `goto_ctl` equals bits 5:0.
- R6: A captured byte `1000aaaa` asserts `class_oh` bit 2 (ALU class), and `alu_fn` equals bits 3:0.
- R7: A captured byte `10xyzzzz` with `xy` not `00` asserts `class_oh` bit 4 (no-operation class).
- R8: After the first load, exactly one bit of `class_oh` is set.
- R9: `class_led` always equals `class_oh`.
- R10: Each field output is zero whenever its class bit in `class_oh` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture strobe for the instruction bus |
| instr_in | input | 8 | Instruction bus byte |
| class_oh | output | 5 | One-hot class: 0 move, 1 A/B set, 2 ALU, 3 branch, 4 no-op |
| class_led | output | 5 | Indicator drive, same as class_oh |
| mov_arg | output | 6 | Move class parameters |
| setab_sel | output | 1 | A/B set target select |
| setab_val | output | 5 | A/B set immediate value |
| goto_ctl | output | 6 | Branch condition and control bits |
| alu_fn | output | 4 | ALU function code |

## Verification
The assertions assume that `load` and `instr_in` are steady around each rising edge and never unknown once reset is released. The stimulus meets this by changing both inputs only on falling edges. The assertions also take no position on what `instr_in` carries when `load` is low. The bench therefore scrambles the bus on those cycles, so that holding is checked against changing data. Directed bytes hit each prefix boundary and every no-op sub-code of the `10` quarter. A long run of random bytes, with random load strobes, follows.

// File: rtl/instr_class_decoder.sv
module instr_class_decoder #(
  parameter int IW = 8,
  localparam int PW = IW - 2,
  localparam int NC = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] instr_in,
  output logic [NC-1:0] class_oh,
  output logic [NC-1:0] class_led,
  output logic [PW-1:0] mov_arg,
  output logic          setab_sel,
  output logic [PW-2:0] setab_val,
  output logic [PW-1:0] goto_ctl,
  output logic [PW-3:0] alu_fn
);
  logic [IW-1:0] ir;
  logic          vld;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ir  <= '0;
      vld <= 1'b0;
    end else if (load) begin
      ir  <= instr_in;
      vld <= 1'b1;
    end

  logic [1:0] pre;
  logic [1:0] sub;
  assign pre = ir[IW-1:IW-2];
  assign sub = ir[IW-3:IW-4];

  logic is_mov, is_set, is_alu, is_goto, is_nop;
  assign is_mov  = vld && pre == 2'b00;
  assign is_set  = vld && pre == 2'b01;
  assign is_goto = vld && pre == 2'b11;
  assign is_alu  = vld && pre == 2'b10 && sub == 2'b00;
  assign is_nop  = vld && pre == 2'b10 && sub != 2'b00;

  assign class_oh  = {is_nop, is_goto, is_alu, is_set, is_mov};
  assign class_led = class_oh;

  assign mov_arg   = is_mov  ? ir[PW-1:0] : '0;
  assign setab_sel = is_set  & ir[PW-1];
  assign setab_val = is_set  ? ir[PW-2:0] : '0;
  assign goto_ctl  = is_goto ? ir[PW-1:0] : '0;
  assign alu_fn    = is_alu  ? ir[PW-3:0] : '0;
endmodule

module instr_class_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic [7:0] instr_in,
  input logic [4:0] class_oh,
  input logic [4:0] class_led,
  input logic [5:0] mov_arg,
  input logic       setab_sel,
  input logic [4:0] setab_val,
  input logic [5:0] goto_ctl,
  input logic [3:0] alu_fn
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else if (load) seen <= 1'b1;

  AST_IDLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !seen |-> class_oh == 5'd0); // R1
  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(class_oh) && $stable(mov_arg) && $stable(goto_ctl)); // R2
  AST_MOV_DECODE: assert property (@(posedge clk) disable iff (!rst_n) load && instr_in[7:6] == 2'b00 |=> class_oh[0] && mov_arg == $past(instr_in[5:0])); // R3
  AST_SETAB_DECODE: assert property (@(posedge clk) disable iff (!rst_n) load && instr_in[7:6] == 2'b01 |=> class_oh[1] && setab_sel == $past(instr_in[5]) && setab_val == $past(instr_in[4:0])); // R4
  AST_GOTO_DECODE: assert property (@(posedge clk) disable iff (!rst_n) load && instr_in[7:6] == 2'b11 |=> class_oh[3] && goto_ctl == $past(instr_in[5:0])); // R5
  AST_ALU_DECODE: assert property (@(posedge clk) disable iff (!rst_n) load && instr_in[7:4] == 4'b1000 |=> class_oh[2] && alu_fn == $past(instr_in[3:0])); // R6
  AST_NOP_DECODE: assert property (@(posedge clk) disable iff (!rst_n) load && instr_in[7:6] == 2'b10 && instr_in[5:4] != 2'b00 |=> class_oh[4]); // R7
  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n) seen |-> $countones(class_oh) == 1); // R8
  AST_LED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) class_led == class_oh); // R9
  AST_IDLE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!class_oh[0] -> mov_arg == 6'd0) && (!class_oh[1] -> (setab_val == 5'd0 && !setab_sel)) &&
    (!class_oh[3] -> goto_ctl == 6'd0) && (!class_oh[2] -> alu_fn == 4'd0)); // R10
endmodule

bind instr_class_decoder instr_class_decoder_chk u_chk (.*);

// File: tb/sim_instr_class_decoder.sv
`timescale 1ns/1ps
module sim_instr_class_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] instr_in = 8'h00;
  logic [4:0] class_oh, class_led;
  logic [5:0] mov_arg, goto_ctl;
  logic       setab_sel;
  logic [4:0] setab_val;
  logic [3:0] alu_fn;

  always #2.5 clk = ~clk;

  instr_class_decoder u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .instr_in(instr_in),
    .class_oh(class_oh), .class_led(class_led), .mov_arg(mov_arg),
    .setab_sel(setab_sel), .setab_val(setab_val), .goto_ctl(goto_ctl), .alu_fn(alu_fn)
  );

  int n_chk = 0, n_bad = 0;
  int m_ir = 0;
  bit m_vld = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: class index and fields from the held byte
  task automatic compare_all(string ctx);
    int cls, top, mid;
    int e_mov, e_sel, e_val, e_goto, e_alu;
    top = (m_ir >> 6) & 3;
    mid = (m_ir >> 4) & 3;
    e_mov = 0; e_sel = 0; e_val = 0; e_goto = 0; e_alu = 0;
    if (!m_vld) cls = -1;
    else if (top == 0) begin cls = 0; e_mov = m_ir % 64; end
    else if (top == 1) begin cls = 1; e_sel = (m_ir / 32) % 2; e_val = m_ir % 32; end
    else if (top == 3) begin cls = 3; e_goto = m_ir % 64; end
    else if (mid == 0) begin cls = 2; e_alu = m_ir % 16; end
    else cls = 4;
    if (cls < 0)       chk({ctx, " R1"}, "class_oh", int'(class_oh), 0);
    else if (cls == 0) chk({ctx, " R3"}, "class_oh", int'(class_oh), 1);
    else if (cls == 1) chk({ctx, " R4"}, "class_oh", int'(class_oh), 2);
    else if (cls == 2) chk({ctx, " R6"}, "class_oh", int'(class_oh), 4);
    else if (cls == 3) chk({ctx, " R5"}, "class_oh", int'(class_oh), 8);
    else               chk({ctx, " R7"}, "class_oh", int'(class_oh), 16);
    if (m_vld) chk({ctx, " R8"}, "ones", $countones(class_oh), 1);
    chk({ctx, " R9"}, "class_led", int'(class_led), int'(class_oh));
    chk({ctx, (cls == 0) ? " R3" : " R10"}, "mov_arg", int'(mov_arg), e_mov);
    chk({ctx, (cls == 1) ? " R4" : " R10"}, "setab_sel", int'(setab_sel), e_sel);
    chk({ctx, (cls == 1) ? " R4" : " R10"}, "setab_val", int'(setab_val), e_val);
    chk({ctx, (cls == 3) ? " R5" : " R10"}, "goto_ctl", int'(goto_ctl), e_goto);
    chk({ctx, (cls == 2) ? " R6" : " R10"}, "alu_fn", int'(alu_fn), e_alu);
  endtask

  // One cycle: at falling edge compare, then drive; model follows at the coming rising edge
  task automatic step(bit ld, logic [7:0] b, string ctx);
    @(negedge clk);
    compare_all(ctx);
    load = ld;
    instr_in = b;
    if (ld) begin m_ir = int'(b); m_vld = 1; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all("reset R1");
    rst_n = 1'b1;
    step(0, 8'hFF, "idle R1");
    step(0, 8'h5A, "idle R1");
    step(1, 8'h00, "R3 low edge");
    step(1, 8'h3F, "R3 high edge");
    step(1, 8'h40, "R4 A");
    step(1, 8'h7F, "R4 B");
    step(1, 8'h80, "R6 low");
    step(1, 8'h8F, "R6 high");
    step(1, 8'h90, "R7 sub1");
    step(1, 8'hA7, "R7 sub2");
    step(1, 8'hBF, "R7 sub3");
    step(1, 8'hC0, "R5 low");
    step(1, 8'hFF, "R5 high");
    step(0, 8'h12, "R2 hold");
    step(0, 8'h83, "R2 hold");
    step(0, 8'h40, "R2 hold");
    step(1, 8'h8A, "R2 reload");
    step(0, 8'hC5, "R2 hold");
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) != 0, 8'($urandom), "random");
    step(0, 8'h00, "final");
    @(negedge clk);
    compare_all("final");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule